// File: doc/BRIEF.md
# H-Bridge Switch Sequencer with Chopper Current Limit

This block sits between the direction, modulation and decay-select inputs of a motor bridge and the four gate-enable lines of the bridge: a high-side and a low-side switch on each of two legs. Each leg is driven either high or low, and the decay mode decides the leg levels during the modulation-off phase. Every commanded low-to-high change on a leg passes through a dead-time window with both switches of that leg off. This keeps the two switches of a leg from conducting at the same time.

A digital over-current comparator input starts a chopper. For a programmable off-time of 24, 43, 62 or 80 microseconds, all low-side switches are held off. The comparator is ignored while the off-time runs. On the first comparator hit after the bridge is enabled, the chop is held back for a 10 microsecond blanking window, so that a fault monitor elsewhere can see whether the current keeps rising. A disable input and a fault shutdown input both turn all four switches off at the next clock. Neither of them disturbs the mode inputs.

Microsecond timing comes from a prescaler of `CLK_PER_US` system clocks. The prescaler restarts at the start of each timed window, so each window lasts exactly its length times `CLK_PER_US` clocks.

Top module: `hbridge_chop_ctrl`

## Requirements
- R1: With `pwm_i`=1, `dir_i`=0 drives leg 0 high and leg 1 low, and `dir_i`=1 drives leg 0 low and leg 1 high. A leg driven high has its `hs_on_o` bit at 1 and its `ls_on_o` bit at 0; a leg driven low has the reverse. Bit index equals leg number.
- R2: With `pwm_i`=0 and `fast_decay_i`=0, both legs are driven high for either value of `dir_i`.
- R3: With `pwm_i`=0 and `fast_decay_i`=1, each leg takes the opposite level to the one it has with `pwm_i`=1 and the same `dir_i`.
- R4: A leg's two switch commands are never both 1 in the same cycle. When a leg goes from low to high, both of its commands are 0 for exactly `DEAD_CYC` clocks before its high-side command rises.
- R5: A comparator hit (`ilim_i`=1 sampled while no off-time or blanking runs, after the first hit) forces every `ls_on_o` bit to 0 for exactly off_us × `CLK_PER_US` clocks. off_us is 24, 43, 62 or 80 for `toff_sel_i` codes 0, 1, 2 and 3. The first forced-off cycle is the second cycle after the sampled hit.
- R6: Comparator activity during a running off-time neither restarts nor lengthens it.
- R7: The first comparator hit after reset or after the bridge is re-enabled starts a blanking window of `BLANK_US` × `CLK_PER_US` clocks with no chop. If the comparator is still 1 when the window ends, a chop starts on the next clock.
- R8: `disable_i`=1 turns all four commands to 0 from the next clock for any `dir_i`/`pwm_i`. After release, the outputs again follow the mode inputs.
- R9: `shutdown_i`=1 turns all four commands to 0 from the next clock, overriding every other input.
- R10: After reset, all four commands are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Direction select |
| pwm_i | input | 1 | Modulation input, 1 = drive phase |
| fast_decay_i | input | 1 | Decay mode during pwm low, 1 = fast |
| toff_sel_i | input | 2 | Chopper off-time code |
| disable_i | input | 1 | Tri-state all switches, 1 = off |
| shutdown_i | input | 1 | Fault shutdown request, 1 = off |
| ilim_i | input | 1 | Current-limit comparator |
| hs_on_o | output | 2 | High-side switch commands, bit = leg |
| ls_on_o | output | 2 | Low-side switch commands, bit = leg |

## Verification
A chop can start in the same cycle that a direction change removes the low side of one leg and opens a dead-time window on the other leg. The bench provokes this by raising the comparator during the drive phase and, part way through the off-time, pulsing it again. It then counts the forced-off cycles, which must match the selected code and must not be stretched by the second pulse. The bench also checks that the blanking window on the first hit delays the chop by exactly the window length. Overlap between the two switches of a leg is counted in every sampled cycle across a seeded random run of modes, with the disable input asserted at random.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  localparam int unsigned HBC_N_LEG       = 2;
  localparam int unsigned HBC_MAX_OFF_US  = 80;
  localparam int unsigned HBC_US_W        = $clog2(HBC_MAX_OFF_US + 1);

  // Chopper off-time in microseconds for each selection code.
  function automatic logic [HBC_US_W-1:0] hbc_off_us(input logic [1:0] code);
    logic [HBC_US_W-1:0] r;
    case (code)
      2'd0:    r = HBC_US_W'(24);
      2'd1:    r = HBC_US_W'(43);
      2'd2:    r = HBC_US_W'(62);
      default: r = HBC_US_W'(80);
    endcase
    return r;
  endfunction

  // Target leg levels, bit n = 1 means leg n driven high.
  function automatic logic [HBC_N_LEG-1:0] hbc_leg_high(input logic dir,
                                                       input logic pwm,
                                                       input logic fast);
    logic [HBC_N_LEG-1:0] r;
    if (pwm)       r = {dir, ~dir};
    else if (fast) r = {~dir, dir};
    else           r = '1;
    return r;
  endfunction

endpackage

// File: rtl/hbc_us_timer.sv
module hbc_us_timer #(
  parameter int unsigned CLK_PER_US = 4,
  parameter int unsigned UW         = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [UW-1:0] load_us,
  output logic          busy_o
);

  localparam int unsigned PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

  logic          busy_q, busy_d;
  logic [PW-1:0] pre_q, pre_d;
  logic [UW-1:0] us_q, us_d;
  logic          tick;

  assign tick = busy_q && (pre_q == PRE_LAST);

  always_comb begin
    busy_d = busy_q;
    pre_d  = pre_q;
    us_d   = us_q;
    if (clr) begin
      busy_d = 1'b0;
      pre_d  = '0;
      us_d   = '0;
    end else if (start) begin
      busy_d = 1'b1;
      pre_d  = '0;
      us_d   = load_us;
    end else if (tick) begin
      pre_d = '0;
      if (us_q <= UW'(1)) begin
        busy_d = 1'b0;
        us_d   = '0;
      end else begin
        us_d = us_q - UW'(1);
      end
    end else if (busy_q) begin
      pre_d = pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pre_q  <= '0;
      us_q   <= '0;
    end else begin
      busy_q <= busy_d;
      pre_q  <= pre_d;
      us_q   <= us_d;
    end
  end

  assign busy_o = busy_q;

  // R5: a running window always has microseconds left to count
  p_window_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (us_q != '0));

endmodule

// File: rtl/hbc_chopper.sv
module hbc_chopper #(
  parameter int unsigned CLK_PER_US = 4,
  parameter int unsigned BLANK_US   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ilim,
  input  logic [1:0] toff_sel,
  output logic       ls_block_o
);
  import hbc_pkg::*;

  logic arm_q, arm_d;
  logic off_busy, blank_busy;
  logic idle, blank_start, off_start;

  assign idle        = run && !off_busy && !blank_busy;
  assign blank_start = idle && ilim && arm_q;
  assign off_start   = idle && ilim && !arm_q;

  always_comb begin
    arm_d = arm_q;
    if (!run)             arm_d = 1'b1;
    else if (blank_start) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b1;
    else        arm_q <= arm_d;
  end

  hbc_us_timer #(.CLK_PER_US(CLK_PER_US), .UW(HBC_US_W)) u_off_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!run),
    .start   (off_start),
    .load_us (hbc_off_us(toff_sel)),
    .busy_o  (off_busy)
  );

  hbc_us_timer #(.CLK_PER_US(CLK_PER_US), .UW(HBC_US_W)) u_blank_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!run),
    .start   (blank_start),
    .load_us (HBC_US_W'(BLANK_US)),
    .busy_o  (blank_busy)
  );

  assign ls_block_o = off_busy;

  // R5: an off-time only begins after a sampled comparator hit
  p_chop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_busy) |-> $past(ilim));

  // R7: blanking and off-time never overlap
  p_blank_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(off_busy && blank_busy));

endmodule

// File: rtl/hbc_leg_drv.sv
module hbc_leg_drv #(
  parameter int unsigned DEAD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic want_high,
  input  logic ls_block,
  output logic hs_o,
  output logic ls_o
);

  localparam int unsigned DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DC_LAST = DW'(DEAD_CYC);

  logic          hs_q, hs_d;
  logic          ls_q, ls_d;
  logic [DW-1:0] dc_q, dc_d;

  always_comb begin
    hs_d = 1'b0;
    ls_d = 1'b0;
    dc_d = '0;
    if (en) begin
      if (want_high) begin
        if (hs_q || (dc_q == DC_LAST)) begin
          hs_d = 1'b1;
        end else begin
          dc_d = dc_q + DW'(1);
        end
      end else begin
        ls_d = !ls_block;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
      dc_q <= '0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
      dc_q <= dc_d;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  // R4: no shoot-through on this leg
  p_no_shoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));

  // R4: high side only rises out of a cycle with both switches off
  p_dead_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> ($past(!ls_q) && $past(en)));

endmodule

// File: rtl/hbridge_chop_ctrl.sv
module hbridge_chop_ctrl #(
  parameter int unsigned CLK_PER_US = 4,
  parameter int unsigned DEAD_CYC   = 16,
  parameter int unsigned BLANK_US   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_i,
  input  logic       pwm_i,
  input  logic       fast_decay_i,
  input  logic [1:0] toff_sel_i,
  input  logic       disable_i,
  input  logic       shutdown_i,
  input  logic       ilim_i,
  output logic [1:0] hs_on_o,
  output logic [1:0] ls_on_o
);
  import hbc_pkg::*;

  logic                 run;
  logic                 chop_block;
  logic [HBC_N_LEG-1:0] leg_high;

  assign run      = !disable_i && !shutdown_i;
  assign leg_high = hbc_leg_high(dir_i, pwm_i, fast_decay_i);

  hbc_chopper #(.CLK_PER_US(CLK_PER_US), .BLANK_US(BLANK_US)) u_chop (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .ilim       (ilim_i),
    .toff_sel   (toff_sel_i),
    .ls_block_o (chop_block)
  );

  for (genvar g = 0; g < HBC_N_LEG; g++) begin : g_leg
    hbc_leg_drv #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (run),
      .want_high (leg_high[g]),
      .ls_block  (chop_block),
      .hs_o      (hs_on_o[g]),
      .ls_o      (ls_on_o[g])
    );
  end

  // R9: shutdown clears every switch by the next clock
  p_shutdown_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (hs_on_o == 2'b00 && ls_on_o == 2'b00));

  // R8: disable clears every switch by the next clock
  p_disable_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> (hs_on_o == 2'b00 && ls_on_o == 2'b00));

  // R5: while chopping, no low side is on in the following cycle
  p_chop_ls_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chop_block |=> (ls_on_o == 2'b00));

endmodule

// File: tb/hbridge_chop_ctrl_tb_top.sv
module hbridge_chop_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int DEAD       = 16;
  localparam int BLANK      = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir_i, pwm_i, fast_decay_i, disable_i, shutdown_i, ilim_i;
  logic [1:0] toff_sel_i;
  logic [1:0] hs_on_o, ls_on_o;

  int n_run  = 0;
  int n_fail = 0;
  int overlap_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_chop_ctrl #(.CLK_PER_US(CPU), .DEAD_CYC(DEAD), .BLANK_US(BLANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .pwm_i(pwm_i),
    .fast_decay_i(fast_decay_i), .toff_sel_i(toff_sel_i),
    .disable_i(disable_i), .shutdown_i(shutdown_i), .ilim_i(ilim_i),
    .hs_on_o(hs_on_o), .ls_on_o(ls_on_o)
  );

  // Expected {hs1,hs0,ls1,ls0} from the mode rules.
  function automatic logic [3:0] exp_out(input logic dir, input logic pwm,
                                         input logic fast, input logic on);
    logic l0, l1;
    if (pwm) begin l0 = !dir; l1 = dir; end
    else if (!fast) begin l0 = 1'b1; l1 = 1'b1; end
    else begin l0 = dir; l1 = !dir; end
    if (!on) return 4'b0000;
    return {l1, l0, !l1, !l0};
  endfunction

  function automatic int off_us(input logic [1:0] c);
    case (c)
      2'd0: return 24;
      2'd1: return 43;
      2'd2: return 62;
      default: return 80;
    endcase
  endfunction

  task automatic chk4(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chkn(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(negedge clk)
    if (rst_n && ((hs_on_o & ls_on_o) != 2'b00)) overlap_cnt++;

  // One chop with a mid-window pulse; returns forced-off length.
  task automatic chop_len(input logic [1:0] sel, output int len);
    int d;
    toff_sel_i = sel;
    ilim_i = 1'b1;
    @(negedge clk);
    ilim_i = 1'b0;
    @(negedge clk);
    d = 0;
    while (ls_on_o[1] == 1'b0 && d < 5000) begin
      d++;
      ilim_i = (d == (off_us(sel) * CPU) / 2);
      @(negedge clk);
    end
    ilim_i = 1'b0;
    len = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int c, len;
    logic d, p, f, dis;
    rst_n = 1'b0;
    dir_i = 0; pwm_i = 0; fast_decay_i = 0; toff_sel_i = 2'd0;
    disable_i = 0; shutdown_i = 0; ilim_i = 0;
    idle(3);
    chk4("R10 reset state", {hs_on_o, ls_on_o}, 4'b0000);
    rst_n = 1'b1;

    // R1 drive phase, both directions
    pwm_i = 1; dir_i = 0; idle(DEAD + 4);
    chk4("R1 pwm=1 dir=0", {hs_on_o, ls_on_o}, exp_out(0, 1, 0, 1));
    dir_i = 1; idle(DEAD + 4);
    chk4("R1 pwm=1 dir=1", {hs_on_o, ls_on_o}, exp_out(1, 1, 0, 1));
    // R2 slow decay both directions
    pwm_i = 0; idle(DEAD + 4);
    chk4("R2 slow dir=1", {hs_on_o, ls_on_o}, 4'b1100);
    dir_i = 0; idle(DEAD + 4);
    chk4("R2 slow dir=0", {hs_on_o, ls_on_o}, 4'b1100);
    // R3 fast decay reverses the drive phase
    fast_decay_i = 1; idle(DEAD + 4);
    chk4("R3 fast dir=0", {hs_on_o, ls_on_o}, 4'b1001);
    dir_i = 1; idle(DEAD + 4);
    chk4("R3 fast dir=1", {hs_on_o, ls_on_o}, 4'b0110);

    // R4 dead time on leg 1 going low to high
    fast_decay_i = 0; pwm_i = 1; dir_i = 0; idle(DEAD + 4);
    dir_i = 1;
    @(negedge clk);
    c = 0;
    while (hs_on_o[1] == 1'b0 && ls_on_o[1] == 1'b0 && c < 1000) begin
      c++;
      @(negedge clk);
    end
    chkn("R4 dead gap clocks", c, DEAD);
    chk4("R4 after gap", {hs_on_o, ls_on_o}, exp_out(1, 1, 0, 1));

    // R7 first hit is blanked, chop follows while comparator stays high
    dir_i = 0; toff_sel_i = 2'd0; idle(DEAD + 4);
    ilim_i = 1;
    @(negedge clk);
    c = 0;
    while (ls_on_o[1] == 1'b1 && c < 5000) begin
      c++;
      @(negedge clk);
    end
    ilim_i = 0;
    chkn("R7 blank window clocks", c, BLANK * CPU + 2);
    c = 1;
    @(negedge clk);
    while (ls_on_o[1] == 1'b0 && c < 5000) begin
      c++;
      @(negedge clk);
    end
    chkn("R5 off-time after blank code0", c, off_us(2'd0) * CPU);
    idle(4);

    // R5/R6 each code, with a pulse in the middle of the window
    for (int s = 0; s < 4; s++) begin
      chop_len(2'(s), len);
      chkn($sformatf("R5 R6 off-time code%0d", s), len, off_us(2'(s)) * CPU);
      idle(4);
      chk4("R5 low side back on", {hs_on_o, ls_on_o}, exp_out(0, 1, 0, 1));
    end

    // R8 disable, with mode inputs moving underneath
    fast_decay_i = 1;
    disable_i = 1;
    @(negedge clk);
    chk4("R8 disable next clock", {hs_on_o, ls_on_o}, 4'b0000);
    dir_i = 1; idle(5); dir_i = 0; pwm_i = 0; idle(5);
    chk4("R8 disable held", {hs_on_o, ls_on_o}, 4'b0000);
    disable_i = 0; idle(DEAD + 4);
    chk4("R8 resume after disable", {hs_on_o, ls_on_o}, exp_out(0, 0, 1, 1));

    // R9 shutdown overrides, also in the middle of a chop
    pwm_i = 1; idle(DEAD + 4);
    shutdown_i = 1;
    @(negedge clk);
    chk4("R9 shutdown next clock", {hs_on_o, ls_on_o}, 4'b0000);
    ilim_i = 1; idle(3); ilim_i = 0;
    chk4("R9 shutdown held", {hs_on_o, ls_on_o}, 4'b0000);
    shutdown_i = 0; idle(DEAD + 4);
    chk4("R9 resume after shutdown", {hs_on_o, ls_on_o}, exp_out(0, 1, 1, 1));

    // Random modes with occasional disable
    void'($urandom(32'd4242));
    for (int k = 0; k < 60; k++) begin
      d = 1'($urandom); p = 1'($urandom); f = 1'($urandom);
      dis = (($urandom % 4) == 0);
      dir_i = d; pwm_i = p; fast_decay_i = f; disable_i = dis;
      idle(DEAD + 4);
      chk4($sformatf("R1 R2 R3 R8 random step %0d", k),
           {hs_on_o, ls_on_o}, exp_out(d, p, f, !dis));
    end
    disable_i = 0;
    chkn("R4 overlap cycles", overlap_cnt, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule